// File: doc/BRIEF.md
# Vector Command Stripmine Expander

This block takes decoded vector commands from a scalar front end and hands them, one issue event at a time, to a SIMD issue port. Incoming commands land in a small internal queue. That queue keeps the front end decoupled from the vector back end. A command whose stripmine flag is clear issues once, exactly as received. A command whose flag is set becomes four separate issue events in consecutive cycles, as far as the issue side allows. Each of those events steps the destination register and both source registers by one. Downstream logic treats each event as an independent instruction.

Before a command starts, a 64-entry busy scoreboard is checked. Every issue event marks its destination register busy, and a writeback pulse clears one register. A command may not start while any register it would touch is busy, across all four steps when stripmined. Once it has started, its remaining steps go out without a further check. The queued command is released only when its last event is accepted. Both edges of the block use valid/ready handshakes.

Top module: `vstrip_expander`

## Requirements
- R1: After reset, `issue_valid` is 0 and `disp_ready` is 1.
- R2: A command with `disp_strip` = 1 produces exactly four issue events, in order. Event k (k = 0..3) carries the command's opcode and the indices vd+k, vs1+k and vs2+k.
- R3: Register indices are 6-bit unsigned binary values, so the stepped indices wrap modulo 64. A base of 62 yields 62, 63, 0, 1.
- R4: A command with `disp_strip` = 0 produces exactly one issue event, with its opcode and base indices unchanged.
- R5: While `issue_valid` is 1 and `issue_ready` is 0, `issue_valid` stays 1 and the opcode and all three indices hold steady. No event is lost or repeated under backpressure.
- R6: The input queue accepts FIFO_DEPTH commands while the issue side is stalled. `disp_ready` is 0 while the queue is full.
- R7: A queued command leaves the queue only when its final issue event is accepted. With a full queue, `disp_ready` stays 0 after three of a stripmined command's events and becomes 1 after the fourth.
- R8: Each accepted issue event marks its destination register busy. A cycle with `wb_valid` = 1 marks register `wb_reg` free.
- R9: A command does not start while any register in the span of vd, vs1 or vs2 is busy. The span is four registers when stripmined and one otherwise. The command starts once every register in its span is free.
- R10: Once a stripmined command's first event is accepted, its remaining events are presented in the following cycles without a new scoreboard check. This holds even when a later step reads a register marked by an earlier step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | A dispatched command is offered |
| disp_ready | output | 1 | The input queue can take a command |
| disp_op | input | OP_W | Opcode of the dispatched command |
| disp_strip | input | 1 | Expand the command into four stepped events |
| disp_vd | input | 6 | Base destination register |
| disp_vs1 | input | 6 | Base first source register |
| disp_vs2 | input | 6 | Base second source register |
| issue_valid | output | 1 | An issue event is presented |
| issue_ready | input | 1 | The SIMD side accepts the event |
| issue_op | output | OP_W | Opcode of the event |
| issue_vd | output | 6 | Destination register of the event |
| issue_vs1 | output | 6 | First source register of the event |
| issue_vs2 | output | 6 | Second source register of the event |
| wb_valid | input | 1 | Writeback pulse that frees a register |
| wb_reg | input | 6 | Register freed by the writeback |

## Verification
The checks on held payload assume a fixed environment contract. The issue side may withdraw `issue_ready` at any time. The dispatch side holds a command stable until it is taken. A writeback names only a register the environment wants freed, and a writeback to a free register is harmless. The stimulus drives `disp_valid` only through a task that drops it right after the accepting edge. It sends writebacks one per cycle, only for destinations already issued or for a deliberate clear-all. It toggles `issue_ready` either at random or from a credit count, so stalls land on every step of an expansion.

// File: rtl/vstrip_pkg.sv
package vstrip_pkg;
  localparam int REG_W   = 6;
  localparam int NREG    = 1 << REG_W;
  localparam int STRIP_N = 4;
  localparam int STEP_W  = $clog2(STRIP_N);
  localparam int OP_W    = 8;

  typedef logic [REG_W-1:0] vreg_t;

  typedef struct packed {
    logic [OP_W-1:0] op;
    logic            strip;
    vreg_t           vd;
    vreg_t           vs1;
    vreg_t           vs2;
  } vcmd_t;

  // index of step k above a base register, modulo the register count
  function automatic vreg_t step_reg(vreg_t base, vreg_t k);
    return base + k;
  endfunction

  // one-hot set of every register an operand covers
  function automatic logic [NREG-1:0] span_mask(vreg_t base, logic strip);
    logic [NREG-1:0] m;
    m = '0;
    for (int k = 0; k < STRIP_N; k++) begin
      if (k == 0 || strip) m[step_reg(base, vreg_t'(k))] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/vstrip_fifo.sv
module vstrip_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R6: occupancy never passes the configured depth
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/vstrip_scoreboard.sv
module vstrip_scoreboard
  import vstrip_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_v,
  input  vreg_t           set_idx,
  input  logic            clr_v,
  input  vreg_t           clr_idx,
  output logic [NREG-1:0] busy
);
  logic [NREG-1:0] busy_d;

  always_comb begin
    busy_d = busy;
    if (clr_v) busy_d[clr_idx] = 1'b0;
    if (set_v) busy_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= '0;
    else        busy <= busy_d;
  end

  // R8: an issued destination is busy in the following cycle
  a_r8_mark: assert property (@(posedge clk) disable iff (!rst_n)
    set_v |=> busy[$past(set_idx)]);

  // R8: a writeback frees its register unless the same register is re-issued
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_v && !(set_v && set_idx == clr_idx) |=> !busy[$past(clr_idx)]);
endmodule

// File: rtl/vstrip_sequencer.sv
module vstrip_sequencer
  import vstrip_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  vcmd_t           head,
  input  logic            head_valid,
  input  logic [NREG-1:0] busy,
  output logic            issue_valid,
  input  logic            issue_ready,
  output logic [OP_W-1:0] issue_op,
  output vreg_t           issue_vd,
  output vreg_t           issue_vs1,
  output vreg_t           issue_vs2,
  output logic            issue_fire,
  output logic            head_pop
);
  logic [STEP_W-1:0] step_q;
  logic              last_step;
  logic              hazard;
  logic              may_go;
  logic [NREG-1:0]   touch;

  assign touch = span_mask(head.vd, head.strip) | span_mask(head.vs1, head.strip)
               | span_mask(head.vs2, head.strip);
  assign hazard    = |(touch & busy);
  assign may_go    = (step_q != '0) || !hazard;
  assign last_step = !head.strip || (step_q == STEP_W'(STRIP_N - 1));

  assign issue_valid = head_valid && may_go;
  assign issue_fire  = issue_valid && issue_ready;
  assign head_pop    = issue_fire && last_step;

  assign issue_op  = head.op;
  assign issue_vd  = step_reg(head.vd,  vreg_t'(step_q));
  assign issue_vs1 = step_reg(head.vs1, vreg_t'(step_q));
  assign issue_vs2 = step_reg(head.vs2, vreg_t'(step_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          step_q <= '0;
    else if (issue_fire) step_q <= last_step ? '0 : step_q + STEP_W'(1);
  end

  // R5: a stalled event stays offered with an unchanged payload
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !issue_ready |=>
      issue_valid && $stable({issue_op, issue_vd, issue_vs1, issue_vs2}));

  // R2, R10: the next step follows at once with every index advanced by one
  a_r10_next_step: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire && !last_step |=>
      issue_valid && issue_op == $past(issue_op)
      && issue_vd  == vreg_t'($past(issue_vd)  + vreg_t'(1))
      && issue_vs1 == vreg_t'($past(issue_vs1) + vreg_t'(1))
      && issue_vs2 == vreg_t'($past(issue_vs2) + vreg_t'(1)));
endmodule

// File: rtl/vstrip_expander.sv
module vstrip_expander
  import vstrip_pkg::*;
#(
  parameter int FIFO_DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            disp_valid,
  output logic            disp_ready,
  input  logic [OP_W-1:0] disp_op,
  input  logic            disp_strip,
  input  logic [REG_W-1:0] disp_vd,
  input  logic [REG_W-1:0] disp_vs1,
  input  logic [REG_W-1:0] disp_vs2,
  output logic            issue_valid,
  input  logic            issue_ready,
  output logic [OP_W-1:0] issue_op,
  output logic [REG_W-1:0] issue_vd,
  output logic [REG_W-1:0] issue_vs1,
  output logic [REG_W-1:0] issue_vs2,
  input  logic            wb_valid,
  input  logic [REG_W-1:0] wb_reg
);
  localparam int CMD_W = $bits(vcmd_t);

  vcmd_t           in_cmd, head;
  logic [CMD_W-1:0] head_bits;
  logic            q_full, q_empty;
  logic            issue_fire, head_pop;
  logic [NREG-1:0] busy;

  assign in_cmd     = '{op: disp_op, strip: disp_strip, vd: disp_vd, vs1: disp_vs1, vs2: disp_vs2};
  assign disp_ready = !q_full;
  assign head       = vcmd_t'(head_bits);

  vstrip_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (disp_valid),
    .din   (in_cmd),
    .full  (q_full),
    .pop   (head_pop),
    .dout  (head_bits),
    .empty (q_empty)
  );

  vstrip_scoreboard u_busy (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_v   (issue_fire),
    .set_idx (issue_vd),
    .clr_v   (wb_valid),
    .clr_idx (wb_reg),
    .busy    (busy)
  );

  vstrip_sequencer u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .head        (head),
    .head_valid  (!q_empty),
    .busy        (busy),
    .issue_valid (issue_valid),
    .issue_ready (issue_ready),
    .issue_op    (issue_op),
    .issue_vd    (issue_vd),
    .issue_vs1   (issue_vs1),
    .issue_vs2   (issue_vs2),
    .issue_fire  (issue_fire),
    .head_pop    (head_pop)
  );

  // R7: a full queue frees a slot only on an accepted event
  a_r7_pop_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
    q_full && !issue_fire |=> !disp_ready);
endmodule

// File: tb/vstrip_expander_tb.sv
module vstrip_expander_tb;
  import vstrip_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_valid = 1'b0, disp_strip = 1'b0;
  logic [OP_W-1:0] disp_op = '0;
  logic [REG_W-1:0] disp_vd = '0, disp_vs1 = '0, disp_vs2 = '0;
  logic disp_ready, issue_valid;
  logic issue_ready = 1'b0;
  logic [OP_W-1:0] issue_op;
  logic [REG_W-1:0] issue_vd, issue_vs1, issue_vs2;
  logic wb_valid = 1'b0;
  logic [REG_W-1:0] wb_reg = '0;

  always #5 clk = ~clk;

  vstrip_expander #(.FIFO_DEPTH(2)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
    .disp_strip(disp_strip), .disp_vd(disp_vd), .disp_vs1(disp_vs1), .disp_vs2(disp_vs2),
    .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_op(issue_op),
    .issue_vd(issue_vd), .issue_vs1(issue_vs1), .issue_vs2(issue_vs2),
    .wb_valid(wb_valid), .wb_reg(wb_reg)
  );

  int n_checks = 0, n_fail = 0;
  int fires = 0;
  int credits = 0;
  bit credit_mode = 1'b1;
  bit auto_wb = 1'b1;
  bit done = 1'b0;
  string cur_req = "R2";
  logic [OP_W+3*REG_W-1:0] expq[$];
  logic [REG_W-1:0] wbq[$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: offer a command, record the events it must produce once taken
  task automatic send(logic [OP_W-1:0] op, bit strip, int vd, int vs1, int vs2);
    @(negedge clk);
    disp_valid = 1'b1; disp_op = op; disp_strip = strip;
    disp_vd = REG_W'(vd); disp_vs1 = REG_W'(vs1); disp_vs2 = REG_W'(vs2);
    #1;
    while (!disp_ready) begin @(negedge clk); #1; end
    for (int k = 0; k < (strip ? 4 : 1); k++)
      expq.push_back({op, REG_W'((vd + k) % 64), REG_W'((vs1 + k) % 64), REG_W'((vs2 + k) % 64)});
    @(posedge clk); #1;
    disp_valid = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && (expq.size() != 0 || wbq.size() != 0); i++) @(negedge clk);
    wait_cyc(2);
  endtask

  // monitor: drives ready and writebacks, compares every accepted event
  logic prev_stall = 1'b0;
  logic [OP_W+3*REG_W-1:0] prev_pay = '0;
  always begin
    @(negedge clk);
    if (credit_mode) begin
      if (credits > 0) begin issue_ready = 1'b1; credits--; end
      else issue_ready = 1'b0;
    end else issue_ready = ($urandom % 10) < 7;
    if (wbq.size() != 0) begin wb_valid = 1'b1; wb_reg = wbq.pop_front(); end
    else wb_valid = 1'b0;
    #1;
    if (rst_n) begin
      if (prev_stall) begin
        check(issue_valid === 1'b1, "R5", "valid held under stall", int'(issue_valid), 1);
        check({issue_op, issue_vd, issue_vs1, issue_vs2} === prev_pay, "R5", "payload held",
              int'({issue_vd, issue_vs1, issue_vs2}), int'(prev_pay[3*REG_W-1:0]));
      end
      prev_stall = issue_valid && !issue_ready;
      prev_pay   = {issue_op, issue_vd, issue_vs1, issue_vs2};
      if (issue_valid && issue_ready) begin
        fires++;
        if (expq.size() == 0) check(1'b0, cur_req, "unexpected event", int'(issue_vd), -1);
        else begin
          logic [OP_W+3*REG_W-1:0] e;
          e = expq.pop_front();
          check({issue_op, issue_vd, issue_vs1, issue_vs2} === e, cur_req, "event payload",
                int'({issue_op, issue_vd, issue_vs1, issue_vs2}), int'(e));
        end
        if (auto_wb) wbq.push_back(issue_vd);
      end
    end
  end

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(issue_valid === 1'b0, "R1", "issue_valid after reset", int'(issue_valid), 0);
    check(disp_ready === 1'b1, "R1", "disp_ready after reset", int'(disp_ready), 1);

    // R2 / R4 / R3 directed under random backpressure
    credit_mode = 1'b0;
    cur_req = "R2"; send(8'h11, 1'b1, 0, 8, 16); drain();
    cur_req = "R4"; send(8'h22, 1'b0, 5, 6, 7); drain();
    cur_req = "R3"; send(8'h33, 1'b1, 62, 63, 1); drain();

    // mixed random stream, R2 R4 R5 together
    cur_req = "R2/R4";
    for (int i = 0; i < 60; i++)
      send(8'($urandom), 1'($urandom), $urandom % 64, $urandom % 64, $urandom % 64);
    drain();
    check(expq.size() == 0, "R2", "all expected events seen", expq.size(), 0);

    // R10: later step reads a register an earlier step just marked
    credit_mode = 1'b1; credits = 100000; auto_wb = 1'b0;
    cur_req = "R10";
    f0 = fires;
    send(8'h44, 1'b1, 30, 29, 29);
    wait_cyc(6);
    check(fires - f0 == 4, "R10", "back-to-back steps", fires - f0, 4);

    // R9 / R8: single register conflict, then release by writeback
    cur_req = "R9";
    f0 = fires;
    send(8'h55, 1'b0, 50, 33, 50);
    wait_cyc(8);
    check(fires - f0 == 0, "R9", "stall on busy v33", fires - f0, 0);
    wbq.push_back(6'd33);
    wait_cyc(4);
    check(fires - f0 == 1, "R8", "issue after writeback", fires - f0, 1);

    // R9: conflict only inside the four-wide destination span
    f0 = fires;
    send(8'h66, 1'b1, 27, 40, 40);
    wait_cyc(8);
    check(fires - f0 == 0, "R9", "stall on span reaching v30", fires - f0, 0);
    wbq.push_back(6'd30);
    wait_cyc(8);
    check(fires - f0 == 4, "R9", "span released", fires - f0, 4);

    for (int r = 0; r < 64; r++) wbq.push_back(REG_W'(r));
    drain();
    auto_wb = 1'b1;

    // R6 / R7: fill the queue while stalled, then release step by step
    credits = 0;
    cur_req = "R7";
    send(8'h77, 1'b1, 1, 1, 1);
    send(8'h88, 1'b1, 10, 10, 10);
    wait_cyc(1);
    check(disp_ready === 1'b0, "R6", "full after depth commands", int'(disp_ready), 0);
    f0 = fires;
    credits = 3;
    wait_cyc(5);
    check(fires - f0 == 3, "R7", "three steps taken", fires - f0, 3);
    check(disp_ready === 1'b0, "R7", "no pop before last step", int'(disp_ready), 0);
    credits = 1;
    wait_cyc(3);
    check(disp_ready === 1'b1, "R7", "pop on last step", int'(disp_ready), 1);
    credits = 100000;
    drain();
    check(expq.size() == 0, "R7", "queue drained", expq.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule